// File: doc/BRIEF.md
# Destructive-Read Core Word Memory Controller

This block sequences a word memory whose cells lose their contents when read, in the manner of a magnetic-core stack. A processor starts an operation by raising a request with an address, a write enable and write data. From then on the controller runs a fixed series of internal phases without further handshaking. It raises a one-cycle acknowledge when the series ends.

Each location holds a 13-bit syllable and an odd-parity bit, one storage plane per bit. The 13-bit address picks one of 128 X select lines and one of 64 Y select lines. A read energises the selected location, which forces every selected cell to 0. The pulses on the per-plane sense lines are collected into a word, and a set phase then puts that word back. A write runs the same clearing step, throws away what it senses, and then drives the location toward all ones. During that set phase it raises the inhibit line of every plane whose bit must stay 0.

The drive lines (X select, Y select, clear strobe, set strobe, inhibit) leave the controller and the sense lines come back in. A behavioural plane-stack model, `core_plane_stack`, closes the loop for simulation.

Top module: `core_mem_ctrl`

## Requirements
- R1: While reset is low and in the cycle after it, ack, rdata, perr, clear_drv, set_drv, inhibit and all select lines are 0.
- R2: The X line index is addr[12:6] and the Y line index is addr[5:0]. During clear or set phases exactly x_sel bit addr[12:6] and y_sel bit addr[5:0] are 1. Outside those phases every select line is 0.
- R3: After the edge that accepts a request, the phases run CLEAR for CLEAR_CYC, LATCH for LATCH_CYC and SET for SET_CYC cycles, then DONE. ack is high for exactly one cycle, after CLEAR_CYC+LATCH_CYC+SET_CYC further edges (5 with defaults). clear_drv and set_drv are never high together.
- R4: A read returns the stored 13-bit syllable on rdata, with perr 0 for a word written by this block. Both are valid from the ack cycle and held until the next read completes.
- R5: A read restores what it sensed, so the same location can be read again with the same result.
- R6: During the set phase of a write, inhibit[i] is 1 exactly for the bits i of the stored 14-bit word that are 0. Bits 12:0 are the syllable and bit 13 is the parity.
- R7: The stored parity bit makes the number of ones in the 14-bit word odd.
- R8: A read whose sensed 14-bit word has an even count of ones sets perr to 1. rdata then carries the sensed syllable bits as they were sensed, and that sensed word is what gets restored.
- R9: A request that arrives while an operation is in progress is ignored. A new request is accepted only in the cycle after ack.
- R10: A write leaves rdata and perr unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start an operation (sampled when idle) |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Word address: X index high, Y index low |
| wdata | input | 13 | Syllable to write |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 13 | Syllable from the last read |
| perr | output | 1 | Parity error of the last read |
| x_sel | output | 128 | One-hot X select drive |
| y_sel | output | 64 | One-hot Y select drive |
| clear_drv | output | 1 | Clearing (read) strobe to the array |
| set_drv | output | 1 | Set (write-one) strobe to the array |
| inhibit | output | 14 | Per-plane inhibit, high keeps the bit at 0 |
| sense | input | 14 | Per-plane sense pulses from the array |

## Verification
An operation is accepted at the edge where req is seen while idle. The select lines and clear_drv come up right after that edge. With defaults, ack and a fresh rdata/perr appear after the fifth edge that follows, and ack is gone again after the sixth. The bench drives every input at the falling edge and samples at the next falling edge. It counts rising edges from acceptance, requires ack at exactly the fifth one and not at the sixth, and checks the select and inhibit ports on every sampled cycle while the relevant strobe is high. Restore and the rejection of requests while busy are checked through later reads, and a parity fault is injected on the sense lines between the model and the controller.

// File: rtl/core_pkg.sv
// Shared types and helpers for the core word memory controller.
// Assumes a 13-bit syllable and one odd-parity bit per word.
package core_pkg;
    localparam int SYL_W  = 13;
    localparam int WORD_W = SYL_W + 1;

    // Internal phases of one memory cycle
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CLEAR = 3'd1,
        PH_LATCH = 3'd2,
        PH_SET   = 3'd3,
        PH_DONE  = 3'd4
    } phase_t;

    // Parity bit that makes the full word carry an odd number of ones
    function automatic logic odd_par(input logic [SYL_W-1:0] d);
        return ~(^d);
    endfunction
endpackage

// File: rtl/core_plane_stack.sv
// Behavioural model of a stack of destructive-read bit planes.
// A clear strobe reports each selected cell on its sense line and zeroes it.
// A set strobe drives the selected cells to 1 except where inhibit is high.
// Assumes one-hot selects while a strobe is active; memory starts unknown.
module core_plane_stack #(
    parameter int XW = 7,
    parameter int YW = 6,
    parameter int W  = 14
) (
    input  logic                 clk,
    input  logic [(1<<XW)-1:0]   x_sel,
    input  logic [(1<<YW)-1:0]   y_sel,
    input  logic                 clear_drv,
    input  logic                 set_drv,
    input  logic [W-1:0]         inhibit,
    output logic [W-1:0]         sense
);
    localparam int NX = 1 << XW;
    localparam int NY = 1 << YW;
    localparam int WORDS = 1 << (XW + YW);

    logic [W-1:0]  cells [WORDS];
    logic [XW-1:0] xi;
    logic [YW-1:0] yi;

    // Recover the X line number from its one-hot drive
    always_comb begin
        xi = '0;
        for (int i = 0; i < NX; i++) if (x_sel[i]) xi = XW'(i);
    end

    // Recover the Y line number from its one-hot drive
    always_comb begin
        yi = '0;
        for (int j = 0; j < NY; j++) if (y_sel[j]) yi = YW'(j);
    end

    // Clear-with-sense and inhibited set of the addressed word
    always_ff @(posedge clk) begin
        if (clear_drv) begin
            sense          <= cells[{xi, yi}];
            cells[{xi, yi}] <= '0;
        end else begin
            sense <= '0;
            if (set_drv) cells[{xi, yi}] <= cells[{xi, yi}] | ~inhibit;
        end
    end
endmodule

// File: rtl/core_line_decoder.sv
// Turns a binary line number into a one-hot select drive.
// All lines stay low while the enable is low.
module core_line_decoder #(
    parameter int SEL_W = 7
) (
    input  logic                   en,
    input  logic [SEL_W-1:0]       idx,
    output logic [(1<<SEL_W)-1:0]  lines
);
    localparam int N = 1 << SEL_W;

    // One comparator per line
    for (genvar g = 0; g < N; g++) begin : g_line
        assign lines[g] = en && (idx == SEL_W'(g));
    end
endmodule

// File: rtl/core_phase_seq.sv
// Phase sequencer: IDLE -> CLEAR -> LATCH -> SET -> DONE -> IDLE.
// Each timed phase lasts its parameter in cycles (each at least 1).
// A start is only taken in IDLE, so a cycle always finishes its restore.
module core_phase_seq
    import core_pkg::*;
#(
    parameter int CLEAR_CYC = 2,
    parameter int LATCH_CYC = 1,
    parameter int SET_CYC   = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase,
    output logic   last
);
    localparam int MAX_A = (CLEAR_CYC > LATCH_CYC) ? CLEAR_CYC : LATCH_CYC;
    localparam int MAX_D = (MAX_A > SET_CYC) ? MAX_A : SET_CYC;
    localparam int CW    = $clog2(MAX_D + 1);

    logic [CW-1:0] cnt;

    assign last = (cnt == '0);

    // Phase register and per-phase down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_CLEAR;
                    cnt   <= CW'(CLEAR_CYC - 1);
                end
                PH_CLEAR: if (last) begin
                    phase <= PH_LATCH;
                    cnt   <= CW'(LATCH_CYC - 1);
                end else cnt <= cnt - 1'b1;
                PH_LATCH: if (last) begin
                    phase <= PH_SET;
                    cnt   <= CW'(SET_CYC - 1);
                end else cnt <= cnt - 1'b1;
                PH_SET: if (last) phase <= PH_DONE;
                        else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R9: DONE always hands back to IDLE before another start is taken
    a_r9_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |=> (phase == PH_IDLE));
    // R3: the clear phase is always followed by the latch phase
    a_r3_clear_then_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CLEAR && last) |=> (phase == PH_LATCH));
endmodule

// File: rtl/core_mem_ctrl.sv
// Controller for a destructive-read word memory with odd parity.
// Captures a request when idle, clears the addressed word while gathering
// sense pulses, then rewrites either the sensed word (read) or the new word
// (write) via per-plane inhibit. ack pulses for one cycle at the end.
module core_mem_ctrl
    import core_pkg::*;
#(
    parameter int XW        = 7,
    parameter int YW        = 6,
    parameter int CLEAR_CYC = 2,
    parameter int LATCH_CYC = 1,
    parameter int SET_CYC   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 we,
    input  logic [XW+YW-1:0]     addr,
    input  logic [SYL_W-1:0]     wdata,
    output logic                 ack,
    output logic [SYL_W-1:0]     rdata,
    output logic                 perr,
    output logic [(1<<XW)-1:0]   x_sel,
    output logic [(1<<YW)-1:0]   y_sel,
    output logic                 clear_drv,
    output logic                 set_drv,
    output logic [WORD_W-1:0]    inhibit,
    input  logic [WORD_W-1:0]    sense
);
    localparam int AW = XW + YW;

    phase_t             phase;
    logic               last;
    logic               accept;
    logic               drive_on;
    logic               we_q;
    logic [AW-1:0]      addr_q;
    logic [SYL_W-1:0]   wdata_q;
    logic [WORD_W-1:0]  word_q;
    logic [WORD_W-1:0]  word_now;

    assign accept    = (phase == PH_IDLE) && req;
    assign clear_drv = (phase == PH_CLEAR);
    assign set_drv   = (phase == PH_SET);
    assign drive_on  = clear_drv || set_drv;
    assign ack       = (phase == PH_DONE);
    assign word_now  = word_q | sense;
    assign inhibit   = set_drv ? ~word_q : '0;

    core_phase_seq #(
        .CLEAR_CYC(CLEAR_CYC),
        .LATCH_CYC(LATCH_CYC),
        .SET_CYC  (SET_CYC)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(accept),
        .phase(phase),
        .last (last)
    );

    core_line_decoder #(.SEL_W(XW)) u_xdec (
        .en(drive_on), .idx(addr_q[AW-1:YW]), .lines(x_sel)
    );

    core_line_decoder #(.SEL_W(YW)) u_ydec (
        .en(drive_on), .idx(addr_q[YW-1:0]), .lines(y_sel)
    );

    // Request capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            we_q    <= we;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // Sense accumulation, then the word to be set (sensed or new)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (accept) begin
            word_q <= '0;
        end else if (phase == PH_CLEAR) begin
            word_q <= word_now;
        end else if (phase == PH_LATCH && last) begin
            word_q <= we_q ? {odd_par(wdata_q), wdata_q} : word_now;
        end else if (phase == PH_LATCH) begin
            word_q <= word_now;
        end
    end

    // Read result and parity check, updated only by reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            perr  <= 1'b0;
        end else if (phase == PH_LATCH && last && !we_q) begin
            rdata <= word_now[SYL_W-1:0];
            perr  <= ~(^word_now);
        end
    end

    // R2: exactly one X and one Y line while a strobe is active
    a_r2_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        drive_on |-> ($onehot(x_sel) && $onehot(y_sel)));
    // R2: no select line while no strobe is active
    a_r2_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_on |-> ($countones(x_sel) == 0 && $countones(y_sel) == 0));
    // R3: clearing and setting never overlap
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear_drv && set_drv));
    // R3: ack is a single-cycle pulse
    a_r3_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R5: ack only ever follows a completed set (restore) phase
    a_r5_restore_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(set_drv));
    // R7: a written word always carries an odd count of ones
    a_r7_odd_store: assert property (@(posedge clk) disable iff (!rst_n)
        (set_drv && we_q) |-> (^(~inhibit) == 1'b1));
    // R10: a write leaves the read result untouched
    a_r10_write_keeps_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && we_q) |-> ($stable(rdata) && $stable(perr)));
endmodule

// File: tb/tb_core_mem_ctrl.sv
module tb_core_mem_ctrl;
    localparam int XW = 7;
    localparam int YW = 6;
    localparam int LAT = 5;   // CLEAR_CYC + LATCH_CYC + SET_CYC defaults

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic         we = 1'b0;
    logic [12:0]  addr = '0;
    logic [12:0]  wdata = '0;
    logic         ack;
    logic [12:0]  rdata;
    logic         perr;
    logic [127:0] x_sel;
    logic [63:0]  y_sel;
    logic         clear_drv;
    logic         set_drv;
    logic [13:0]  inhibit;
    logic [13:0]  model_sense;
    logic [13:0]  fault_mask = '0;
    logic [13:0]  sense;

    int checks = 0;
    int fails  = 0;
    logic [12:0] last_rd = '0;
    logic        last_pe = 1'b0;

    always #2.5 clk = ~clk;

    assign sense = model_sense ^ fault_mask;

    core_mem_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .perr(perr),
        .x_sel(x_sel), .y_sel(y_sel), .clear_drv(clear_drv),
        .set_drv(set_drv), .inhibit(inhibit), .sense(sense)
    );

    core_plane_stack #(.XW(XW), .YW(YW), .W(14)) u_model (
        .clk(clk), .x_sel(x_sel), .y_sel(y_sel), .clear_drv(clear_drv),
        .set_drv(set_drv), .inhibit(inhibit), .sense(model_sense)
    );

    // {we, addr, wdata, expected rdata, expected perr}
    localparam logic [40:0] VEC [0:9] = '{
        {1'b1, 13'h0000, 13'h0ABC, 13'h0000, 1'b0},
        {1'b1, 13'h1FFF, 13'h1555, 13'h0000, 1'b0},
        {1'b0, 13'h0000, 13'h0000, 13'h0ABC, 1'b0},
        {1'b0, 13'h1FFF, 13'h0000, 13'h1555, 1'b0},
        {1'b0, 13'h0000, 13'h0000, 13'h0ABC, 1'b0},
        {1'b1, 13'h0040, 13'h1FFF, 13'h0000, 1'b0},
        {1'b1, 13'h0001, 13'h0000, 13'h0000, 1'b0},
        {1'b0, 13'h0040, 13'h0000, 13'h1FFF, 1'b0},
        {1'b0, 13'h0001, 13'h0000, 13'h0000, 1'b0},
        {1'b0, 13'h0000, 13'h0000, 13'h0ABC, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Run one operation; checks select lines (R2), inhibit (R6/R7) and ack timing (R3)
    task automatic do_op(input logic w, input logic [12:0] a, input logic [12:0] d);
        int got = -1;
        logic [13:0] exp_word;
        exp_word = {~(^d), d};
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (clear_drv || set_drv) begin
                chk(x_sel == (128'd1 << a[12:6]), "R2 x_sel", x_sel, 128'd1 << a[12:6]);
                chk(y_sel == (64'd1 << a[5:0]), "R2 y_sel", y_sel, 64'd1 << a[5:0]);
            end
            if (set_drv && w) begin
                chk(inhibit == ~exp_word, "R6 inhibit", inhibit, ~exp_word);
                chk(inhibit[13] == ~exp_word[13], "R7 parity bit", inhibit[13], ~exp_word[13]);
            end
            if (ack && got < 0) begin
                got = k;
                break;
            end
        end
        chk(got == LAT, "R3 ack latency", got, LAT);
        @(posedge clk);
        @(negedge clk);
        chk(ack == 1'b0, "R3 ack single", ack, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({ack, rdata, perr} == '0, "R1 outputs in reset", {ack, rdata, perr}, 0);
        chk({clear_drv, set_drv, inhibit} == '0, "R1 drives in reset", {clear_drv, set_drv, inhibit}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(x_sel == '0 && y_sel == '0, "R1 selects after reset", x_sel, 0);

        // Table of operations: R4, R5, R10
        for (int i = 0; i < 10; i++) begin
            do_op(VEC[i][40], VEC[i][39:27], VEC[i][26:14]);
            if (VEC[i][40]) begin
                chk(rdata == last_rd && perr == last_pe, "R10 write keeps rdata",
                    {perr, rdata}, {last_pe, last_rd});
            end else begin
                chk(rdata == VEC[i][13:1], "R4/R5 read data", rdata, VEC[i][13:1]);
                chk(perr == VEC[i][0], "R4 parity clean", perr, VEC[i][0]);
                last_rd = rdata;
                last_pe = perr;
            end
        end

        // R8: fault on sense plane 0 of a word stored as 0x2000
        do_op(1'b1, 13'h0005, 13'h0000);
        fault_mask = 14'h0001;
        do_op(1'b0, 13'h0005, 13'h0000);
        fault_mask = '0;
        chk(perr == 1'b1, "R8 perr on even word", perr, 1);
        chk(rdata == 13'h0001, "R8 sensed data", rdata, 13'h0001);
        do_op(1'b0, 13'h0005, 13'h0000);
        chk(rdata == 13'h0001 && perr == 1'b1, "R8 sensed word restored",
            {perr, rdata}, {1'b1, 13'h0001});

        // R9: write request held during a busy read is ignored
        do_op(1'b1, 13'h000A, 13'h0123);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 13'h0009; wdata = '0;
        @(posedge clk);
        @(negedge clk);
        we = 1'b1; addr = 13'h000A; wdata = 13'h1111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(clear_drv == 1'b0 && set_drv == 1'b0, "R9 no new cycle started",
            {clear_drv, set_drv}, 0);
        do_op(1'b0, 13'h000A, 13'h0000);
        chk(rdata == 13'h0123, "R9 busy request ignored", rdata, 13'h0123);

        // R1: reset in mid-operation returns drives to rest
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 13'h0000;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk({ack, clear_drv, set_drv, perr} == '0 && rdata == '0, "R1 mid-op reset",
            {ack, clear_drv, set_drv, perr, rdata}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        summary();
        $finish;
    end
endmodule